// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access presented to it, whether the access may proceed. Software programs up to sixteen protection regions through a simple register-write port. Each region has a base address, a power-of-two size, a mask that switches off any of its eight equal slices, and a set of memory attributes. Two global switches turn the checker on and allow unmatched privileged accesses to fall through to the default memory map.

On the access side the block takes an address and three qualifiers: write, privileged and instruction fetch. One cycle later it returns whether a region was hit, which region won, the attributes of that region, and a fault flag. When regions overlap, the highest-numbered matching region wins. The fault flag combines the region's access-permission code with the access kind and the execute-never bit.

Configuration writes and accesses share the same clock edge. An access presented in the same cycle as a write is judged against the configuration that was in force before that write.

Top module: `mprot_checker`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `rsp_hit`, `rsp_region`, `rsp_fault` and `rsp_attr` are all zero, and the checker is switched off.
- R2: While the checker is switched off (control bit 0 clear), every access gives `rsp_fault`=0, `rsp_hit`=0, `rsp_region`=0 and `rsp_attr`=0.
- R3: A region matches when it is enabled, its size code is between 0 and 27 (span 2^(code+5) bytes), and the address lies in [base, base+span). Codes 28 to 31 never match. The response appears on the outputs one clock after the access is presented.
- R4: When several regions match, `rsp_region` and `rsp_attr` come from the highest-numbered one.
- R5: A region whose base is not a multiple of its span never matches.
- R6: For size codes of 3 or more, subregion-mask bit k blocks the k-th eighth of the region, counted from the base, so an address in that eighth does not match. For codes 0 to 2 the mask has no effect.
- R7: On a hit, `rsp_attr` = {tex[2:0], ap[2:0], xn, shareable, cacheable, bufferable} (bit 0 = bufferable, bit 3 = xn, bits 6:4 = ap, bits 9:7 = tex). Without a hit, `rsp_attr` is 0 and `rsp_region` is 0.
- R8: The ap code sets the permissions. 0: no access at all. 1: privileged read-write only. 2: privileged read-write, unprivileged read-only. 3: read-write for both levels. 5: privileged read-only only. 4, 6 and 7: read-only for both levels. A fetch counts as a read. A denied access sets `rsp_fault`.
- R9: An instruction fetch that hits a region with xn set faults, whatever the ap code.
- R10: With the checker on and no region hit, a privileged access is permitted only if the background bit (control bit 1) is set. An unprivileged access always faults.
- R11: A write with `cfg_kind`=0 loads the control bits. `cfg_kind`=1 loads region `cfg_region`'s base from `cfg_data[31:5]`, with the low bits taken as zero. `cfg_kind`=2 loads enable [0], size code [5:1], subregion mask [15:8], bufferable [16], cacheable [17], shareable [18], xn [19], ap [22:20] and tex [26:24]. A write takes effect for accesses presented from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 control, 1 region base, 2 region attributes |
| cfg_region | input | 4 | Region number for kinds 1 and 2 |
| cfg_data | input | 32 | Write data |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_fetch | input | 1 | Access is an instruction fetch |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | 4 | Winning region number |
| rsp_fault | output | 1 | Access is denied |
| rsp_attr | output | 10 | Attributes of the winning region |

## Verification
Directed patterns come first. Overlapping regions nested at different sizes separate the highest-wins rule from lowest-wins or first-found. A base that is misaligned against its own size checks that the region is rejected instead of having its address truncated. Subregion probes on a 256-byte and a 32-byte region show whether the mask is honoured, and whether it is skipped below the threshold. Every ap code is then swept across all privilege, write and fetch combinations, which tells the permission codes apart from each other. A long run follows with random configuration writes interleaved with accesses aimed near programmed bases. Its job is to expose timing slips between a write and the first access that sees it.

// File: rtl/mprot_pkg.sv
package mprot_pkg;

    localparam int SIZE_W = 5;
    localparam int SRD_W  = 8;

    localparam logic [1:0] KIND_CTRL = 2'd0;
    localparam logic [1:0] KIND_BASE = 2'd1;
    localparam logic [1:0] KIND_ATTR = 2'd2;

    // Attribute bundle, packed so that bit 0 is bufferable and bits 9:7 are tex
    typedef struct packed {
        logic [2:0] tex;
        logic [2:0] ap;
        logic       xn;
        logic       shr;
        logic       cch;
        logic       buf_en;
    } attr_t;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [SRD_W-1:0]  srd;
        attr_t             attr;
    } rcfg_t;

endpackage

// File: rtl/mprot_region_match.sv
module mprot_region_match
    import mprot_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  rcfg_t             cfg,
    output logic              hit
);
    localparam int MAX_CODE = ADDR_W - 5;

    logic [ADDR_W:0]   span;
    logic [ADDR_W-1:0] low_mask;
    logic [2:0]        sub;
    logic              code_ok;
    logic              aligned;
    logic              in_range;
    logic              sub_ok;

    always_comb begin
        span     = (ADDR_W+1)'(1) << (cfg.size + 5);
        low_mask = ADDR_W'(span - (ADDR_W+1)'(1));
        code_ok  = cfg.size <= SIZE_W'(MAX_CODE);
        aligned  = (base & low_mask) == '0;
        in_range = ((addr ^ base) & ~low_mask) == '0;
        // top three offset bits select the eighth
        sub      = 3'((addr & low_mask) >> (cfg.size + 2));
        sub_ok   = (cfg.size < SIZE_W'(3)) || !cfg.srd[sub];
        hit      = cfg.en && code_ok && aligned && in_range && sub_ok;
    end

endmodule

// File: rtl/mprot_perm.sv
module mprot_perm (
    input  logic [2:0] ap,
    input  logic       xn,
    input  logic       priv,
    input  logic       write,
    input  logic       fetch,
    output logic       allow
);
    logic rd_ok;
    logic wr_ok;

    always_comb begin
        unique case (ap)
            3'd0:    begin rd_ok = 1'b0; wr_ok = 1'b0; end
            3'd1:    begin rd_ok = priv; wr_ok = priv; end
            3'd2:    begin rd_ok = 1'b1; wr_ok = priv; end
            3'd3:    begin rd_ok = 1'b1; wr_ok = 1'b1; end
            3'd5:    begin rd_ok = priv; wr_ok = 1'b0; end
            default: begin rd_ok = 1'b1; wr_ok = 1'b0; end
        endcase
        if (fetch)      allow = rd_ok && !xn;
        else if (write) allow = wr_ok;
        else            allow = rd_ok;
    end

endmodule

// File: rtl/mprot_prio.sv
module mprot_prio #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] sel
);
    // later indices overwrite earlier ones: highest number wins
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mprot_checker.sv
module mprot_checker
    import mprot_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic              acc_fetch,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic              rsp_fault,
    output logic [9:0]        rsp_attr
);
    typedef struct packed {
        logic                                mpu_en;
        logic                                bg_en;
        logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base;
        rcfg_t [NUM_REGIONS-1:0]             rcfg;
        logic                                hit;
        logic [IDX_W-1:0]                    region;
        logic                                fault;
        attr_t                               attr;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] region_en_q;
    logic                   any_hit;
    logic [IDX_W-1:0]       win;
    attr_t                  win_attr;
    logic                   allow;
    logic                   mpu_en_q;
    logic                   unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_data[7:6], cfg_data[23], cfg_data[ADDR_W-1:27]};
    assign mpu_en_q        = state_q.mpu_en;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        mprot_region_match #(.ADDR_W(ADDR_W)) u_match (
            .addr (acc_addr),
            .base (state_q.base[g]),
            .cfg  (state_q.rcfg[g]),
            .hit  (hit_vec[g])
        );
        assign region_en_q[g] = state_q.rcfg[g].en;
    end

    mprot_prio #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
        .req (hit_vec),
        .any (any_hit),
        .sel (win)
    );

    assign win_attr = state_q.rcfg[win].attr;

    mprot_perm u_perm (
        .ap    (win_attr.ap),
        .xn    (win_attr.xn),
        .priv  (acc_priv),
        .write (acc_write),
        .fetch (acc_fetch),
        .allow (allow)
    );

    always_comb begin
        state_d = state_q;

        if (cfg_we) begin
            unique case (cfg_kind)
                KIND_CTRL: begin
                    state_d.mpu_en = cfg_data[0];
                    state_d.bg_en  = cfg_data[1];
                end
                KIND_BASE: begin
                    state_d.base[cfg_region] = {cfg_data[ADDR_W-1:5], 5'b0};
                end
                KIND_ATTR: begin
                    state_d.rcfg[cfg_region].en          = cfg_data[0];
                    state_d.rcfg[cfg_region].size        = cfg_data[5:1];
                    state_d.rcfg[cfg_region].srd         = cfg_data[15:8];
                    state_d.rcfg[cfg_region].attr.buf_en = cfg_data[16];
                    state_d.rcfg[cfg_region].attr.cch    = cfg_data[17];
                    state_d.rcfg[cfg_region].attr.shr    = cfg_data[18];
                    state_d.rcfg[cfg_region].attr.xn     = cfg_data[19];
                    state_d.rcfg[cfg_region].attr.ap     = cfg_data[22:20];
                    state_d.rcfg[cfg_region].attr.tex    = cfg_data[26:24];
                end
                default: ;
            endcase
        end

        state_d.hit    = 1'b0;
        state_d.region = '0;
        state_d.attr   = '0;
        state_d.fault  = 1'b0;
        if (state_q.mpu_en) begin
            if (any_hit) begin
                state_d.hit    = 1'b1;
                state_d.region = win;
                state_d.attr   = win_attr;
                state_d.fault  = !allow;
            end else begin
                state_d.fault  = !(state_q.bg_en && acc_priv);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rsp_hit    = state_q.hit;
    assign rsp_region = state_q.region;
    assign rsp_fault  = state_q.fault;
    assign rsp_attr   = state_q.attr;

endmodule

// File: rtl/mprot_checker_sva.sv
module mprot_checker_sva #(
    parameter int NUM_REGIONS = 16,
    parameter int IDX_W       = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mpu_en,
    input logic [NUM_REGIONS-1:0] region_en,
    input logic                   acc_priv,
    input logic                   acc_fetch,
    input logic                   rsp_hit,
    input logic [IDX_W-1:0]       rsp_region,
    input logic                   rsp_fault,
    input logic [9:0]             rsp_attr
);
    // switched-off checker never faults nor hits
    assert_off_permits_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(mpu_en) |-> (!rsp_fault && !rsp_hit && rsp_attr == '0));

    // reported region must have been enabled when the access was judged
    assert_hit_enabled_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> ((($past(region_en) >> rsp_region) & NUM_REGIONS'(1)) != '0));

    assert_nohit_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_attr == '0 && rsp_region == '0));

    assert_xn_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(acc_fetch) && rsp_hit && rsp_attr[3]) |-> rsp_fault);

    assert_user_miss_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(mpu_en) && !$past(acc_priv) && !rsp_hit) |-> rsp_fault);

endmodule

bind mprot_checker mprot_checker_sva #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .mpu_en     (mpu_en_q),
    .region_en  (region_en_q),
    .acc_priv   (acc_priv),
    .acc_fetch  (acc_fetch),
    .rsp_hit    (rsp_hit),
    .rsp_region (rsp_region),
    .rsp_fault  (rsp_fault),
    .rsp_attr   (rsp_attr)
);

// File: tb/tb_mprot_checker.sv
module tb_mprot_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_kind;
    logic [3:0]  cfg_region;
    logic [31:0] cfg_data;
    logic [31:0] acc_addr;
    logic        acc_write, acc_priv, acc_fetch;
    logic        rsp_hit, rsp_fault;
    logic [3:0]  rsp_region;
    logic [9:0]  rsp_attr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mprot_checker dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_region(cfg_region), .cfg_data(cfg_data), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_priv(acc_priv), .acc_fetch(acc_fetch),
        .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_fault(rsp_fault),
        .rsp_attr(rsp_attr)
    );

    // behavioural reference state
    bit          m_on, m_bg;
    bit          m_en   [16];
    int          m_size [16];
    bit [7:0]    m_srd  [16];
    longint      m_base [16];
    bit [9:0]    m_attr [16];

    function automatic bit ref_match(int r, longint a);
        longint sz;
        longint sub;
        if (!m_en[r] || m_size[r] > 27) return 0;
        sz = 64'd1 << (m_size[r] + 5);
        if (m_base[r] % sz != 0) return 0;
        if (a < m_base[r] || a >= m_base[r] + sz) return 0;
        if (m_size[r] >= 3) begin
            sub = (a - m_base[r]) / (sz / 8);
            if (m_srd[r][sub] == 1'b1) return 0;
        end
        return 1;
    endfunction

    function automatic bit ref_allow(bit [2:0] ap, bit xn, bit pv, bit wr, bit fe);
        bit rd, wt;
        case (ap)
            3'd0: begin rd = 0;  wt = 0;  end
            3'd1: begin rd = pv; wt = pv; end
            3'd2: begin rd = 1;  wt = pv; end
            3'd3: begin rd = 1;  wt = 1;  end
            3'd5: begin rd = pv; wt = 0;  end
            default: begin rd = 1; wt = 0; end
        endcase
        if (fe) return rd && !xn;
        return wr ? wt : rd;
    endfunction

    function automatic bit [15:0] ref_resp(longint a, bit pv, bit wr, bit fe);
        int w;
        w = -1;
        if (!m_on) return 16'h0;
        for (int r = 0; r < 16; r++) if (ref_match(r, a)) w = r;
        if (w < 0) return {1'b0, 4'd0, !(m_bg && pv), 10'd0};
        return {1'b1, 4'(w), !ref_allow(m_attr[w][6:4], m_attr[w][3], pv, wr, fe), m_attr[w]};
    endfunction

    function automatic bit [31:0] mk_attr(bit en, int size, bit [7:0] srd, bit [2:0] ap,
                                          bit xn, bit [2:0] tex, bit s, bit c, bit b);
        return {5'd0, tex, 1'b0, ap, xn, s, c, b, srd, 2'b00, 5'(size), en};
    endfunction

    task automatic check(string tag, bit [15:0] exp);
        bit [15:0] got;
        got = {rsp_hit, rsp_region, rsp_fault, rsp_attr};
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got hit=%0b rgn=%0d flt=%0b attr=%h, expected hit=%0b rgn=%0d flt=%0b attr=%h",
                     tag, got[15], got[14:11], got[10], got[9:0], exp[15], exp[14:11], exp[10], exp[9:0]);
        end
    endtask

    task automatic step(bit we, bit [1:0] kind, bit [3:0] rg, bit [31:0] data,
                        bit [31:0] a, bit wr, bit pv, bit fe, string tag);
        bit [15:0] exp;
        cfg_we = we; cfg_kind = kind; cfg_region = rg; cfg_data = data;
        acc_addr = a; acc_write = wr; acc_priv = pv; acc_fetch = fe;
        exp = ref_resp(longint'(a), pv, wr, fe);   // judged on pre-write config (R11)
        if (we) begin
            case (kind)
                2'd0: begin m_on = data[0]; m_bg = data[1]; end
                2'd1: m_base[rg] = longint'({data[31:5], 5'b0});
                2'd2: begin
                    m_en[rg]   = data[0];
                    m_size[rg] = int'(data[5:1]);
                    m_srd[rg]  = data[15:8];
                    m_attr[rg] = {data[26:24], data[22:20], data[19:16]};
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(tag, exp);
    endtask

    task automatic acc(bit [31:0] a, bit wr, bit pv, bit fe, string tag);
        step(0, 2'd0, 4'd0, 32'd0, a, wr, pv, fe, tag);
    endtask

    task automatic wr_cfg(bit [1:0] kind, bit [3:0] rg, bit [31:0] data);
        step(1, kind, rg, data, 32'hFFFF_FFE0, 0, 1, 0, "R11 write-cycle");
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) begin
            m_en[r] = 0; m_size[r] = 0; m_srd[r] = 0; m_base[r] = 0; m_attr[r] = 0;
        end
        m_on = 0; m_bg = 0;
        rst = 1; cfg_we = 0; cfg_kind = 0; cfg_region = 0; cfg_data = 0;
        acc_addr = 0; acc_write = 0; acc_priv = 0; acc_fetch = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 16'h0);
        rst = 0;

        // R2: switched off, even with a denying region programmed
        wr_cfg(2'd1, 4'd9, 32'h0000_0000);
        wr_cfg(2'd2, 4'd9, mk_attr(1, 27, 8'h00, 3'd0, 1, 3'd0, 0, 0, 0));
        acc(32'h1234_5678, 1, 0, 0, "R2 off");
        acc(32'h0000_0040, 0, 0, 1, "R2 off fetch");
        wr_cfg(2'd2, 4'd9, 32'h0);

        // switch on, background off
        wr_cfg(2'd0, 4'd0, 32'h1);
        acc(32'h8000_0000, 0, 1, 0, "R10 priv miss no bg");
        acc(32'h8000_0000, 0, 0, 0, "R10 user miss");

        // R3/R7: region 0 at 0, 4 MB, read-only both, normal write-back
        wr_cfg(2'd1, 4'd0, 32'h0000_0000);
        step(1, 2'd2, 4'd0, mk_attr(1, 17, 8'h00, 3'd6, 0, 3'd1, 0, 1, 1),
             32'h0000_1000, 0, 1, 0, "R11 same-cycle old cfg");
        acc(32'h0000_1000, 0, 1, 0, "R3 hit R7 attr");
        acc(32'h003F_FFFF, 0, 0, 0, "R3 last byte");
        acc(32'h0040_0000, 0, 1, 0, "R3 just past");
        acc(32'h0000_2000, 1, 1, 0, "R8 ap6 write");

        // R4: region 1 inside region 0, xn set, privileged only
        wr_cfg(2'd1, 4'd1, 32'h0010_0000);
        wr_cfg(2'd2, 4'd1, mk_attr(1, 15, 8'h00, 3'd1, 1, 3'd0, 1, 0, 0));
        acc(32'h0010_0010, 1, 1, 0, "R4 overlap high wins");
        acc(32'h0010_0010, 0, 1, 1, "R9 xn fetch");
        acc(32'h0020_0000, 0, 1, 0, "R4 outside inner");

        // R5: misaligned base
        wr_cfg(2'd1, 4'd2, 32'h0500_1100);
        wr_cfg(2'd2, 4'd2, mk_attr(1, 8, 8'h00, 3'd3, 0, 3'd0, 0, 0, 0));
        acc(32'h0500_1100, 0, 1, 0, "R5 misaligned");
        acc(32'h0500_0000, 0, 1, 0, "R5 aligned part");

        // R6: 256 B region, eighth 2 blocked; 32 B region mask ignored
        wr_cfg(2'd1, 4'd3, 32'h2000_0000);
        wr_cfg(2'd2, 4'd3, mk_attr(1, 3, 8'h04, 3'd3, 0, 3'd0, 0, 0, 0));
        acc(32'h2000_0040, 0, 1, 0, "R6 blocked eighth");
        acc(32'h2000_005F, 0, 1, 0, "R6 blocked end");
        acc(32'h2000_0060, 0, 1, 0, "R6 open eighth");
        acc(32'h2000_003F, 0, 1, 0, "R6 open below");
        wr_cfg(2'd1, 4'd4, 32'h3000_0000);
        wr_cfg(2'd2, 4'd4, mk_attr(1, 0, 8'hFF, 3'd3, 0, 3'd0, 0, 0, 0));
        acc(32'h3000_0000, 0, 0, 0, "R6 small mask ignored");
        acc(32'h3000_001F, 1, 0, 0, "R6 small mask ignored end");

        // R3: invalid size code
        wr_cfg(2'd1, 4'd6, 32'h0000_0000);
        wr_cfg(2'd2, 4'd6, mk_attr(1, 29, 8'h00, 3'd3, 0, 3'd0, 0, 0, 0));
        acc(32'h0000_0100, 0, 1, 0, "R3 code 29");

        // R8/R9: sweep every ap code and access kind on region 5
        wr_cfg(2'd1, 4'd5, 32'h4000_0000);
        for (int ap = 0; ap < 8; ap++) begin
            for (int x = 0; x < 2; x++) begin
                wr_cfg(2'd2, 4'd5, mk_attr(1, 7, 8'h00, 3'(ap), x[0], 3'd2, 1, 0, 1));
                for (int k = 0; k < 8; k++)
                    acc(32'h4000_0010, k[0], k[1], k[2], x ? "R9 xn sweep" : "R8 ap sweep");
            end
        end

        // R10: background on
        wr_cfg(2'd0, 4'd0, 32'h3);
        acc(32'h9000_0000, 1, 1, 0, "R10 priv bg");
        acc(32'h9000_0000, 0, 0, 0, "R10 user bg");
        // R2 again after switching off
        wr_cfg(2'd0, 4'd0, 32'h2);
        acc(32'h0010_0010, 0, 0, 1, "R2 off again");
        wr_cfg(2'd0, 4'd0, 32'h3);

        // random run
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit [31:0] a;
            r = $urandom_range(0, 15);
            if ($urandom_range(0, 9) == 0) begin
                int kd;
                kd = $urandom_range(0, 9);
                if (kd == 0)
                    step(1, 2'd0, 4'(r), {30'd0, 2'($urandom)}, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R11 random ctrl");
                else if (kd < 5) begin
                    int sh;
                    sh = $urandom_range(5, 31);
                    step(1, 2'd1, 4'(r), $urandom & ~((32'd1 << sh) - 1) | ($urandom_range(0, 3) == 0 ? 32'h100 : 32'h0),
                         $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R5 random base");
                end else
                    step(1, 2'd2, 4'(r), mk_attr(1'($urandom_range(0, 4) != 0), $urandom_range(0, 31), 8'($urandom),
                         3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)),
                         $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R4 random attr");
            end else begin
                a = 32'(m_base[r]) + ($urandom >> $urandom_range(0, 31));
                acc(a, 1'($urandom), 1'($urandom), 1'($urandom), "R3 R4 R6 random access");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule